// File: doc/BRIEF.md
# Saturating Accumulator Arithmetic Unit

This block holds a 32-bit accumulator together with the arithmetic and logic that update it. On each enabled cycle it applies one operation to the accumulator: an add or subtract with a supplied operand (optionally with the held carry folded in), a bitwise combination with the operand, or a one-place shift or rotate of the accumulator through the carry bit. The result is written back on the next rising clock edge.

Signed overflow from the add/subtract group sets a sticky overflow flag. A mode input chooses whether an overflowing result is clamped to the most positive or most negative 32-bit two's-complement value, or written back wrapped. A second mode input chooses whether the one-place right shift keeps the sign or inserts a zero. An input marks operands that came from a shift-by-16 path. For those operands, add may only set the carry and subtract may only clear it. Zero-detect and overflow outputs are provided for branch conditions.

Top module: `sat_acc_unit`

## Requirements
- R1: While reset is asserted, and until the first enabled operation after release, acc reads 0, carry reads 1, ov_flag reads 0 and eq reads 1.
- R2: The op codes are NOP=0, ADD=1, SUB=2, ADDC=3, SUBB=4, AND=5, OR=6, XOR=7, SFL=8, SFR=9, ROL=10 and ROR=11. ADD writes acc+operand and sets carry to the unsigned carry-out. SUB writes acc-operand and sets carry to 0 on borrow and to 1 otherwise.
- R3: With ovm=1, a signed overflow in ADD/SUB/ADDC/SUBB writes 0x7FFFFFFF for positive overflow or 0x80000000 for negative overflow, and sets ov_flag.
- R4: With ovm=0, a signed overflow writes the wrapped 32-bit result and still sets ov_flag.
- R5: ov_flag stays at 1 until an ov_clr pulse clears it. When ov_clr and a new overflow occur in the same cycle, the flag stays set.
- R6: ADDC writes acc+operand+carry. SUBB writes acc-operand-1 when carry is 0 and acc-operand when carry is 1. Both use the carry held before the operation and update carry the same way as ADD and SUB do.
- R7: With shift16=1, ADD sets carry on carry-out and otherwise leaves it unchanged. SUB clears carry on borrow and otherwise leaves it unchanged.
- R8: AND, OR and XOR write the bitwise result and leave both carry and ov_flag unchanged.
- R9: SFL moves acc bit 31 into carry and shifts a 0 into bit 0, whatever the value of sxm. ROL moves bit 31 into carry and the old carry into bit 0.
- R10: SFR moves acc bit 0 into carry and fills bit 31 with the old bit 31 when sxm=1, or with 0 when sxm=0. ROR moves bit 0 into carry and the old carry into bit 31.
- R11: eq is 1 exactly when acc is zero and follows acc in the same cycle.
- R12: When en=0, acc, carry and ov_flag hold their values (apart from an ov_clr clear).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Apply op this cycle |
| op | input | 4 | Operation code |
| operand | input | 32 | Second operand |
| shift16 | input | 1 | Operand came from the shift-by-16 path |
| ovm | input | 1 | 1: saturate on overflow, 0: wrap |
| sxm | input | 1 | 1: arithmetic right shift, 0: logical |
| ov_clr | input | 1 | Clear the sticky overflow flag |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry bit |
| ov_flag | output | 1 | Sticky overflow flag, also the branch-on-overflow condition |
| eq | output | 1 | Accumulator equals zero |

## Verification
The accumulator, carry and overflow flag change on the first rising edge after an enabled operation is presented, and eq follows one combinational step later. The bench drives each operation on a falling edge, removes it on the next falling edge and samples all four outputs at that point, which is half a cycle after the edge that updated them. Reset release passes through a two-stage synchronizer, so the bench waits three cycles after release before it drives any operation. Known accumulator and carry values are set up only through logic operations and SFL.

// File: rtl/sat_acc_pkg.sv
package sat_acc_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_ADDC = 4'd3,
    OP_SUBB = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SFL  = 4'd8,
    OP_SFR  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11
  } acc_op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/sat_acc_addsub.sv
module sat_acc_addsub
  import sat_acc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  acc_op_e      op_i,
  input  logic         carry_i,
  input  logic         shift16_i,
  input  logic         ovm_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic         is_sub;
  logic         use_c;
  logic         cin;
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic [W-1:0] raw;
  logic         cout;

  always_comb begin
    is_sub = (op_i == OP_SUB) || (op_i == OP_SUBB);
    use_c  = (op_i == OP_ADDC) || (op_i == OP_SUBB);
    cin    = use_c ? carry_i : is_sub;
    b_eff  = is_sub ? ~opnd_i : opnd_i;
    full   = {1'b0, acc_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    raw    = full[W-1:0];
    cout   = full[W];
    // two's-complement overflow: like-signed inputs, result sign flipped
    ovf_o  = (acc_i[W-1] == b_eff[W-1]) && (raw[W-1] != acc_i[W-1]);
    if (ovf_o && ovm_i)
      res_o = acc_i[W-1] ? NEG_MIN : POS_MAX;
    else
      res_o = raw;
    // cout is "carry" for add and "no borrow" for subtract
    if (shift16_i && op_i == OP_ADD)
      carry_o = carry_i | cout;
    else if (shift16_i && op_i == OP_SUB)
      carry_o = carry_i & cout;
    else
      carry_o = cout;
  end
endmodule

// File: rtl/sat_acc_shift.sv
module sat_acc_shift
  import sat_acc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic         carry_i,
  input  acc_op_e      op_i,
  input  logic         sxm_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  always_comb begin
    res_o   = acc_i;
    carry_o = carry_i;
    unique case (op_i)
      OP_SFL: begin
        res_o   = {acc_i[W-2:0], 1'b0};
        carry_o = acc_i[W-1];
      end
      OP_SFR: begin
        res_o   = {sxm_i & acc_i[W-1], acc_i[W-1:1]};
        carry_o = acc_i[0];
      end
      OP_ROL: begin
        res_o   = {acc_i[W-2:0], carry_i};
        carry_o = acc_i[W-1];
      end
      OP_ROR: begin
        res_o   = {carry_i, acc_i[W-1:1]};
        carry_o = acc_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_acc_logic.sv
module sat_acc_logic
  import sat_acc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  acc_op_e      op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = acc_i & opnd_i;
      OP_OR:   res_o = acc_i | opnd_i;
      OP_XOR:  res_o = acc_i ^ opnd_i;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/sat_acc_unit.sv
module sat_acc_unit
  import sat_acc_pkg::*;
#(
  parameter int W      = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [OP_W-1:0]  op,
  input  logic [W-1:0]     operand,
  input  logic             shift16,
  input  logic             ovm,
  input  logic             sxm,
  input  logic             ov_clr,
  output logic [W-1:0]     acc,
  output logic             carry,
  output logic             ov_flag,
  output logic             eq
);
  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_N-1];

  acc_op_e      op_e;
  logic [W-1:0] as_res, sh_res, lg_res;
  logic         as_carry, sh_carry, as_ovf;
  logic [W-1:0] acc_d;
  logic         carry_d, ov_d;
  logic         acc_q_en;

  assign op_e = acc_op_e'(op);

  sat_acc_addsub #(.W(W)) u_addsub (
    .acc_i(acc), .opnd_i(operand), .op_i(op_e), .carry_i(carry),
    .shift16_i(shift16), .ovm_i(ovm),
    .res_o(as_res), .carry_o(as_carry), .ovf_o(as_ovf)
  );

  sat_acc_shift #(.W(W)) u_shift (
    .acc_i(acc), .carry_i(carry), .op_i(op_e), .sxm_i(sxm),
    .res_o(sh_res), .carry_o(sh_carry)
  );

  sat_acc_logic #(.W(W)) u_logic (
    .acc_i(acc), .opnd_i(operand), .op_i(op_e), .res_o(lg_res)
  );

  // next-state selection
  always_comb begin
    acc_d    = acc;
    carry_d  = carry;
    ov_d     = ov_flag & ~ov_clr;
    acc_q_en = en;
    unique case (op_e)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBB: begin
        acc_d   = as_res;
        carry_d = as_carry;
        ov_d    = (ov_flag & ~ov_clr) | (en & as_ovf);
      end
      OP_AND, OP_OR, OP_XOR: acc_d = lg_res;
      OP_SFL, OP_SFR, OP_ROL, OP_ROR: begin
        acc_d   = sh_res;
        carry_d = sh_carry;
      end
      default: acc_q_en = 1'b0;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc   <= '0;
      carry <= 1'b1;
    end else if (acc_q_en) begin
      acc   <= acc_d;
      carry <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ov_flag <= 1'b0;
    else          ov_flag <= ov_d;
  end

  assign eq = (acc == '0);
endmodule

// File: rtl/sat_acc_checker.sv
module sat_acc_checker
  import sat_acc_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            en,
  input logic [OP_W-1:0] op,
  input logic [W-1:0]    operand,
  input logic            ovm,
  input logic            sxm,
  input logic            ov_clr,
  input logic [W-1:0]    acc,
  input logic            carry,
  input logic            ov_flag
);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!en && !ov_clr) |=> ($stable(acc) && $stable(carry) && $stable(ov_flag)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ov_flag && !ov_clr) |=> ov_flag);

  assert_logic_flags_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && !ov_clr && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> ($stable(carry) && $stable(ov_flag)));

  assert_sfl_carry_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && op == OP_SFL) |=> (carry == $past(acc[W-1]) && !acc[0]));

  assert_sfr_sign_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && op == OP_SFR && sxm) |=> (acc[W-1] == $past(acc[W-1])));

  assert_sat_pos_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && ovm && op == OP_ADD && !acc[W-1] && !operand[W-1]) |=> !acc[W-1]);
endmodule

bind sat_acc_unit sat_acc_checker #(.W(W)) u_sat_acc_checker (
  .clk(clk), .rst_q_n(rst_q_n), .en(en), .op(op), .operand(operand),
  .ovm(ovm), .sxm(sxm), .ov_clr(ov_clr), .acc(acc), .carry(carry),
  .ov_flag(ov_flag)
);

// File: tb/test_sat_acc_unit.sv
module test_sat_acc_unit;
  import sat_acc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  op;
  logic [31:0] operand;
  logic        shift16, ovm, sxm, ov_clr;
  logic [31:0] acc;
  logic        carry, ov_flag, eq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  sat_acc_unit i_sat_acc_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .operand(operand),
    .shift16(shift16), .ovm(ovm), .sxm(sxm), .ov_clr(ov_clr),
    .acc(acc), .carry(carry), .ov_flag(ov_flag), .eq(eq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(acc_op_e o, logic [31:0] b, logic s16 = 1'b0);
    @(negedge clk);
    en = 1'b1; op = o; operand = b; shift16 = s16;
    @(negedge clk);
    en = 1'b0; op = OP_NOP; shift16 = 1'b0;
  endtask

  task automatic load(logic [31:0] v);
    do_op(OP_AND, 32'h0);
    do_op(OP_OR, v);
  endtask

  task automatic set_carry(logic c);
    load({c, 31'b0});
    do_op(OP_SFL, 32'h0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); ov_clr = 1'b1;
    @(negedge clk); ov_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 acc", acc, 32'h0);
    check("R1 carry", {31'b0, carry}, 32'h1);
    check("R1 ov", {31'b0, ov_flag}, 32'h0);
    check("R11 eq at reset", {31'b0, eq}, 32'h1);
  endtask

  task automatic t_add_sub();
    load(32'd5); do_op(OP_ADD, 32'd3);
    check("R2 add", acc, 32'd8);
    check("R2 add no carry", {31'b0, carry}, 32'h0);
    check("R11 eq nonzero", {31'b0, eq}, 32'h0);
    load(32'hFFFFFFFF); do_op(OP_ADD, 32'd1);
    check("R2 add wrap", acc, 32'h0);
    check("R2 add carry", {31'b0, carry}, 32'h1);
    check("R11 eq zero", {31'b0, eq}, 32'h1);
    check("R2 no signed ovf", {31'b0, ov_flag}, 32'h0);
    load(32'd5); do_op(OP_SUB, 32'd7);
    check("R2 sub", acc, 32'hFFFFFFFE);
    check("R2 sub borrow", {31'b0, carry}, 32'h0);
    load(32'd7); do_op(OP_SUB, 32'd5);
    check("R2 sub nb", acc, 32'd2);
    check("R2 sub no borrow", {31'b0, carry}, 32'h1);
  endtask

  task automatic t_saturate();
    ovm = 1'b1;
    load(32'h7FFFFFFF); do_op(OP_ADD, 32'd1);
    check("R3 pos sat", acc, 32'h7FFFFFFF);
    check("R3 ov set", {31'b0, ov_flag}, 32'h1);
    pulse_clr();
    check("R5 clear", {31'b0, ov_flag}, 32'h0);
    load(32'h80000000); do_op(OP_SUB, 32'd1);
    check("R3 neg sat", acc, 32'h80000000);
    check("R3 ov set neg", {31'b0, ov_flag}, 32'h1);
    pulse_clr();
    ovm = 1'b0;
  endtask

  task automatic t_wrap();
    ovm = 1'b0;
    load(32'h7FFFFFFF); do_op(OP_ADD, 32'd1);
    check("R4 wrap", acc, 32'h80000000);
    check("R4 ov set", {31'b0, ov_flag}, 32'h1);
    do_op(OP_ADD, 32'd0);
    check("R5 sticky", {31'b0, ov_flag}, 32'h1);
    load(32'h7FFFFFFF);
    @(negedge clk);
    en = 1'b1; op = OP_ADD; operand = 32'd1; ov_clr = 1'b1;
    @(negedge clk);
    en = 1'b0; op = OP_NOP; ov_clr = 1'b0;
    check("R5 set wins", {31'b0, ov_flag}, 32'h1);
    pulse_clr();
    check("R5 cleared", {31'b0, ov_flag}, 32'h0);
  endtask

  task automatic t_carry_ops();
    set_carry(1'b1); load(32'd10); do_op(OP_ADDC, 32'd5);
    check("R6 addc c1", acc, 32'd16);
    check("R6 addc carry", {31'b0, carry}, 32'h0);
    set_carry(1'b0); load(32'd10); do_op(OP_SUBB, 32'd3);
    check("R6 subb c0", acc, 32'd6);
    check("R6 subb carry", {31'b0, carry}, 32'h1);
    set_carry(1'b1); load(32'd10); do_op(OP_SUBB, 32'd3);
    check("R6 subb c1", acc, 32'd7);
  endtask

  task automatic t_shift16();
    set_carry(1'b1); load(32'd1); do_op(OP_ADD, 32'd2, 1'b1);
    check("R7 add16 sum", acc, 32'd3);
    check("R7 add16 keep", {31'b0, carry}, 32'h1);
    set_carry(1'b0); load(32'hFFFFFFFF); do_op(OP_ADD, 32'd1, 1'b1);
    check("R7 add16 set", {31'b0, carry}, 32'h1);
    set_carry(1'b0); load(32'd5); do_op(OP_SUB, 32'd3, 1'b1);
    check("R7 sub16 keep", {31'b0, carry}, 32'h0);
    set_carry(1'b1); load(32'd3); do_op(OP_SUB, 32'd5, 1'b1);
    check("R7 sub16 clr", {31'b0, carry}, 32'h0);
  endtask

  task automatic t_logic();
    set_carry(1'b1);
    load(32'h0000FF00);
    do_op(OP_AND, 32'h0FF00FF0);
    check("R8 and", acc, 32'h00000F00);
    do_op(OP_OR, 32'h12340000);
    check("R8 or", acc, 32'h12340F00);
    do_op(OP_XOR, 32'hFFFFFFFF);
    check("R8 xor", acc, 32'hEDCBF0FF);
    check("R8 carry kept", {31'b0, carry}, 32'h1);
    check("R8 ov kept", {31'b0, ov_flag}, 32'h0);
  endtask

  task automatic t_left();
    set_carry(1'b0); load(32'h80000001); do_op(OP_SFL, 32'h0);
    check("R9 sfl", acc, 32'h00000002);
    check("R9 sfl carry", {31'b0, carry}, 32'h1);
    sxm = 1'b1;
    load(32'h80000000); do_op(OP_SFL, 32'h0);
    check("R9 sfl sxm ignored", acc, 32'h0);
    sxm = 1'b0;
    set_carry(1'b1); load(32'h40000000); do_op(OP_ROL, 32'h0);
    check("R9 rol", acc, 32'h80000001);
    check("R9 rol carry", {31'b0, carry}, 32'h0);
  endtask

  task automatic t_right();
    sxm = 1'b1;
    load(32'h80000002); do_op(OP_SFR, 32'h0);
    check("R10 sfr arith", acc, 32'hC0000001);
    check("R10 sfr carry0", {31'b0, carry}, 32'h0);
    sxm = 1'b0;
    load(32'h80000003); do_op(OP_SFR, 32'h0);
    check("R10 sfr logic", acc, 32'h40000001);
    check("R10 sfr carry1", {31'b0, carry}, 32'h1);
    set_carry(1'b1); load(32'h00000002); do_op(OP_ROR, 32'h0);
    check("R10 ror", acc, 32'h80000001);
    check("R10 ror carry", {31'b0, carry}, 32'h0);
  endtask

  task automatic t_hold();
    load(32'h00001234);
    @(negedge clk);
    en = 1'b0; op = OP_ADD; operand = 32'd1;
    @(negedge clk);
    op = OP_SFL;
    @(negedge clk);
    op = OP_NOP;
    check("R12 hold acc", acc, 32'h00001234);
    check("R12 hold carry", {31'b0, carry}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; op = OP_NOP; operand = '0;
    shift16 = 1'b0; ovm = 1'b0; sxm = 1'b0; ov_clr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_add_sub();
    t_saturate();
    t_wrap();
    t_carry_ops();
    t_shift16();
    t_logic();
    t_left();
    t_right();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule